// File: doc/BRIEF.md
# Third-Order Sinc Decimator with Offset Removal and Clamped Output

This block turns the one-bit pulse-density stream of a second-order sigma-delta modulator into 16-bit signed samples. It uses a third-order sinc (cascaded integrator-comb) decimation filter. A bit is taken only on clocks where the modulator enable is high. A one counts as +1 and a zero counts as 0. After every `dec_rate` accepted bits, the comb section forms one unsigned raw result. For a steady input that result equals `dec_rate`^3 times the ones density.

The output stage works on each raw result in three steps:

- It adds a signed 32-bit offset. Setting the offset to minus half of `dec_rate`^3 places a 50 % density at zero.
- It divides by a power of two through an arithmetic right shift of `shift` places.
- It clamps the word to the 16-bit signed range.

Clamping means a badly chosen shift can never wrap the sign of the output. Every clamp sets a fault flag, which stays set until `fault_clr` is pulsed.

The input side is a stream without back-pressure: `mod_en` acts as its valid signal, and the modulator cannot be stalled. The output side is valid/ready:

- `out_valid` rises when a word is produced and stays high, with `out_data` held, until `out_ready` is seen high.
- A word that arrives while an older one is still pending replaces it, because a live modulator stream cannot wait.

`dec_rate` (2 to 1024) may be changed only while reset is asserted. `bias` and `shift` may change at any time; they affect the next word produced.

Top module: `sinc3_decim`

## Requirements
- R1: The filter state advances only on clocks where `mod_en` is 1; the value of `mod_bit` on other clocks has no effect on any output word.
- R2: With a steady input pattern whose period divides `dec_rate`, once three words have passed after reset, every raw result equals `dec_rate`^3 × (ones density): 0 for all zeros and `dec_rate`^3 for all ones.
- R3: Exactly one output word is produced per `dec_rate` accepted input bits.
- R4: The signed 32-bit `bias` (two's complement) is added to the raw result before scaling; a bias of −`dec_rate`^3/2 makes a 50 % density give 0.
- R5: The biased value is shifted right arithmetically by `shift` (0 to 31) places, so negative values round toward minus infinity.
- R6: A scaled value above 32767 is delivered as 16'h7FFF, one below −32768 as 16'h8000; values inside the range, including exactly −32768, are delivered unchanged in two's complement.
- R7: `sat_fault` becomes 1 in the same cycle that a clamped word appears, stays 1 until a clock where `fault_clr` is 1, and a clamp in the same cycle as `fault_clr` leaves it set.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is stable until a new word arrives, which replaces it; `out_valid` falls one clock after it is seen with `out_ready` 1, unless a new word arrives then.
- R9: During reset, `out_valid`, `out_data` and `sat_fault` are all 0.
- R10: `out_valid` rises at the second rising clock edge after the edge that accepts the `dec_rate`-th bit of a decimation period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_en | input | 1 | Modulator bit strobe (input valid) |
| mod_bit | input | 1 | Modulator data bit |
| dec_rate | input | 11 | Decimation ratio, 2 to 1024 |
| bias | input | 32 | Signed offset added to the raw result |
| shift | input | 5 | Right-shift count for scaling |
| fault_clr | input | 1 | Clears the sticky clamp fault |
| out_ready | input | 1 | Downstream accepts the word |
| out_valid | output | 1 | Output word pending |
| out_data | output | 16 | Scaled, clamped signed word |
| sat_fault | output | 1 | Sticky clamp fault flag |

## Verification
The comb result is registered at the edge that takes the last bit of a period, and the scaled word is registered one edge later. A word is therefore due two edges after its final bit, and R10 checks exactly that position by sampling at the falling edges in between. The other checks do not rely on absolute cycle positions: they wait for `out_valid` at a falling edge and compare the word then, and they measure word spacing in accepted bits. Steady values are compared only from the fourth word onward, so the three-word filter transient has passed.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int unsigned ORDER   = 3;
  localparam int unsigned ACC_W   = 32;
  localparam int unsigned OUT_W   = 16;
  localparam int unsigned RATE_W  = 11;
  localparam int unsigned SHIFT_W = 5;
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int unsigned ORDER = sinc3_pkg::ORDER,
  parameter int unsigned ACC_W = sinc3_pkg::ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             bit_in,
  output logic [ACC_W-1:0] acc_out
);
  logic [ACC_W-1:0] acc  [ORDER];
  logic [ACC_W-1:0] feed [ORDER];

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign feed[g] = {{(ACC_W-1){1'b0}}, bit_in};
    end else begin : g_next
      assign feed[g] = acc[g-1];
    end
    // Wrap-around sums; the comb differences recover the exact result.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc[g] <= '0;
      else if (step) acc[g] <= acc[g] + feed[g];
    end
  end

  assign acc_out = acc[ORDER-1];

  // R1: without a strobe, the last integrator does not move
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(acc_out));
endmodule

// File: rtl/sinc3_ctr.sv
module sinc3_ctr #(
  parameter int unsigned RATE_W = sinc3_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [RATE_W-1:0] dec_rate,
  output logic              tick
);
  logic [RATE_W-1:0] cnt;
  logic              last;

  assign last = (cnt >= dec_rate - RATE_W'(1));
  assign tick = step && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= last ? '0 : cnt + RATE_W'(1);
  end

  // R3: a period ends with the count back at zero
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int unsigned ORDER  = sinc3_pkg::ORDER,
  parameter int unsigned ACC_W  = sinc3_pkg::ACC_W,
  parameter int unsigned RATE_W = sinc3_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ACC_W-1:0]  sum_in,
  input  logic [RATE_W-1:0] dec_rate,
  output logic [ACC_W-1:0]  raw,
  output logic              raw_vld
);
  logic [ACC_W-1:0] dly  [ORDER];
  logic [ACC_W-1:0] diff [ORDER+1];

  assign diff[0] = sum_in;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    assign diff[g+1] = diff[g] - dly[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dly[g] <= '0;
      else if (tick) dly[g] <= diff[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw     <= '0;
      raw_vld <= 1'b0;
    end else begin
      raw_vld <= tick;
      if (tick) raw <= diff[ORDER];
    end
  end

  // Upper bound of the raw result: dec_rate to the filter order
  logic [63:0] full_scale;
  always_comb begin
    full_scale = 64'd1;
    for (int k = 0; k < ORDER; k++) full_scale = full_scale * 64'(dec_rate);
  end

  // R2: raw result never exceeds the DC gain (dec_rate fixed since reset)
  assert_raw_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    raw_vld |-> (64'(raw) <= full_scale));
endmodule

// File: rtl/sinc3_out.sv
module sinc3_out #(
  parameter int unsigned ACC_W   = sinc3_pkg::ACC_W,
  parameter int unsigned OUT_W   = sinc3_pkg::OUT_W,
  parameter int unsigned SHIFT_W = sinc3_pkg::SHIFT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ACC_W-1:0]   raw,
  input  logic               raw_vld,
  input  logic [ACC_W-1:0]   bias,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               fault_clr,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_data,
  output logic               sat_fault
);
  localparam int unsigned WIDE_W = ACC_W + 2;
  localparam logic signed [WIDE_W-1:0] POS_LIM = WIDE_W'((2 ** (OUT_W-1)) - 1);
  localparam logic signed [WIDE_W-1:0] NEG_LIM = -POS_LIM - WIDE_W'(1);
  localparam logic [OUT_W-1:0] POS_CODE = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [WIDE_W-1:0] biased;
  logic signed [WIDE_W-1:0] scaled;
  logic                     over_hi;
  logic                     over_lo;
  logic [OUT_W-1:0]         clamped;
  logic                     sat_now;

  always_comb begin
    biased  = $signed({2'b00, raw}) + $signed({{2{bias[ACC_W-1]}}, bias});
    scaled  = biased >>> shift;
    over_hi = (scaled > POS_LIM);
    over_lo = (scaled < NEG_LIM);
    if (over_hi)      clamped = POS_CODE;
    else if (over_lo) clamped = NEG_CODE;
    else              clamped = scaled[OUT_W-1:0];
    sat_now = raw_vld && (over_hi || over_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      sat_fault <= 1'b0;
    end else begin
      if (raw_vld) begin
        out_valid <= 1'b1;
        out_data  <= clamped;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (sat_now)        sat_fault <= 1'b1;
      else if (fault_clr) sat_fault <= 1'b0;
    end
  end

  // R6: a clamped word carries one of the two limit codes
  assert_sat_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_now |=> (out_data == POS_CODE || out_data == NEG_CODE));
  // R7: a clamp always leaves the fault set
  assert_fault_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_now |=> sat_fault);
  // R7: the fault only drops on a clear
  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_fault && !fault_clr) |=> sat_fault);
  // R8: a pending word is held while the consumer stalls
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !raw_vld) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int unsigned P_ORDER   = ORDER,
  parameter int unsigned P_ACC_W   = ACC_W,
  parameter int unsigned P_OUT_W   = OUT_W,
  parameter int unsigned P_RATE_W  = RATE_W,
  parameter int unsigned P_SHIFT_W = SHIFT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mod_en,
  input  logic                 mod_bit,
  input  logic [P_RATE_W-1:0]  dec_rate,
  input  logic [P_ACC_W-1:0]   bias,
  input  logic [P_SHIFT_W-1:0] shift,
  input  logic                 fault_clr,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [P_OUT_W-1:0]   out_data,
  output logic                 sat_fault
);
  logic [P_ACC_W-1:0] integ_sum;
  logic               period_end;
  logic [P_ACC_W-1:0] raw;
  logic               raw_vld;

  sinc3_integ #(.ORDER(P_ORDER), .ACC_W(P_ACC_W)) u_integ (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (mod_en),
    .bit_in  (mod_bit),
    .acc_out (integ_sum)
  );

  sinc3_ctr #(.RATE_W(P_RATE_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (mod_en),
    .dec_rate (dec_rate),
    .tick     (period_end)
  );

  sinc3_comb #(.ORDER(P_ORDER), .ACC_W(P_ACC_W), .RATE_W(P_RATE_W)) u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (period_end),
    .sum_in   (integ_sum),
    .dec_rate (dec_rate),
    .raw      (raw),
    .raw_vld  (raw_vld)
  );

  sinc3_out #(.ACC_W(P_ACC_W), .OUT_W(P_OUT_W), .SHIFT_W(P_SHIFT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw       (raw),
    .raw_vld   (raw_vld),
    .bias      (bias),
    .shift     (shift),
    .fault_clr (fault_clr),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .sat_fault (sat_fault)
  );

  // R10: a word is due two edges after the final bit of its period
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> ##1 out_valid);
endmodule

// File: tb/test_sinc3_decim.sv
`timescale 1ns/1ps
module test_sinc3_decim;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0;
  logic        mod_bit = 1'b0;
  logic [10:0] dec_rate = 11'd8;
  logic [31:0] bias = '0;
  logic [4:0]  shift = '0;
  logic        fault_clr = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [15:0] out_data;
  logic        sat_fault;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  sinc3_decim i_sinc3_decim (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_bit(mod_bit),
    .dec_rate(dec_rate), .bias(bias), .shift(shift), .fault_clr(fault_clr),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .sat_fault(sat_fault)
  );

  typedef struct packed {
    logic [10:0] rate;
    logic [3:0]  pat;
    logic [31:0] bias;
    logic [4:0]  sh;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{11'd128, 4'b0101, 32'hFFF0_0000, 5'd5},
    '{11'd128, 4'b1111, 32'hFFF0_0000, 5'd5},
    '{11'd128, 4'b1111, 32'hFFF0_0000, 5'd6},
    '{11'd128, 4'b0000, 32'hFFF0_0000, 5'd6},
    '{11'd128, 4'b0000, 32'hFFF0_0000, 5'd5},
    '{11'd124, 4'b0111, 32'hFFF1_7420, 5'd5},
    '{11'd124, 4'b0001, 32'hFFF1_7420, 5'd5},
    '{11'd16,  4'b1111, 32'h0000_0000, 5'd0},
    '{11'd200, 4'b1111, 32'h0000_0000, 5'd0},
    '{11'd200, 4'b0000, 32'hFF85_EE00, 5'd0}
  };

  // Expected {fault, word} from the requirements (R2, R4, R5, R6)
  function automatic logic [16:0] exp_word(int unsigned rate, logic [3:0] pat,
                                           logic [31:0] b, int unsigned sh);
    longint raw_v;
    longint s;
    raw_v = longint'(rate) * longint'(rate) * longint'(rate)
            * longint'($countones(pat)) / 4;
    s = raw_v + longint'($signed(b));
    s = s >>> sh;
    if (s > 32767)  return {1'b1, 16'h7FFF};
    if (s < -32768) return {1'b1, 16'h8000};
    return {1'b0, s[15:0]};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [10:0] r, input logic [31:0] b, input logic [4:0] s);
    @(negedge clk);
    rst_n = 1'b0; mod_en = 1'b0; mod_bit = 1'b0; fault_clr = 1'b0; out_ready = 1'b1;
    dec_rate = r; bias = b; shift = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int k = 0;
    int nout = 0;
    int en_cnt = 0;
    int last_cnt = 0;
    bit ph = 1'b0;
    logic [16:0] e;
    e = exp_word(v.rate, v.pat, v.bias, v.sh);
    do_reset(v.rate, v.bias, v.sh);
    while (nout < 5) begin
      @(negedge clk);
      if (out_valid) begin
        nout++;
        if (nout >= 2)
          chk($sformatf("R3 vec%0d spacing", idx), en_cnt - last_cnt, v.rate);
        last_cnt = en_cnt;
        if (nout >= 4)
          chk($sformatf("R1 R2 R4 R5 R6 vec%0d word", idx),
              $signed(out_data), $signed(e[15:0]));
      end
      if (!ph) begin
        mod_en = 1'b1; mod_bit = v.pat[k % 4]; k++; en_cnt++;
      end else begin
        mod_en = 1'b0; mod_bit = ~v.pat[k % 4];
      end
      ph = ~ph;
    end
    chk($sformatf("R7 vec%0d fault", idx), sat_fault, e[16]);
    mod_en = 1'b0;
  endtask

  // Drive all-ones bits every clock until n words have been seen
  task automatic run_ones(input int n, output logic [15:0] last);
    int seen = 0;
    last = '0;
    while (seen < n) begin
      @(negedge clk);
      if (out_valid) begin seen++; last = out_data; end
      mod_en = 1'b1; mod_bit = 1'b1;
    end
    mod_en = 1'b0;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++; n_fails++;
        $display("FAIL watchdog R3 actual=%0d expected=%0d", cycles, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin : main
    logic [15:0] w;
    logic [15:0] held;

    // R9: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    mod_en = 1'b1; mod_bit = 1'b1;
    @(negedge clk);
    chk("R9 out_valid in reset", out_valid, 0);
    chk("R9 out_data in reset", out_data, 0);
    chk("R9 sat_fault in reset", sat_fault, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

    // R10: latency from the last bit of the first period
    do_reset(11'd8, 32'd0, 5'd0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      mod_en = 1'b1; mod_bit = 1'b1;
    end
    @(negedge clk);
    mod_en = 1'b0;
    chk("R10 valid one edge after last bit", out_valid, 0);
    @(negedge clk);
    chk("R10 valid two edges after last bit", out_valid, 1);

    // R8: back-pressure hold, overwrite and release
    @(negedge clk);
    out_ready = 1'b0;
    mod_en = 1'b0;
    run_ones(2, w);
    held = out_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 valid held", out_valid, 1);
      chk("R8 data held", out_data, held);
    end
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      mod_en = 1'b1; mod_bit = 1'b1;
    end
    @(negedge clk);
    mod_en = 1'b0;
    @(negedge clk);
    chk("R8 valid kept over new word", out_valid, 1);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
    chk("R8 valid drops after accept", out_valid, 0);
    out_ready = 1'b1;

    // R7: sticky fault and clear
    do_reset(11'd16, 32'd0, 5'd0);
    run_ones(4, w);
    chk("R2 ones at rate 16", w, 4096);
    chk("R7 no fault before clamp", sat_fault, 0);
    bias = 32'd40000;
    run_ones(2, w);
    chk("R6 clamp high code", w, 16'h7FFF);
    chk("R7 fault after clamp", sat_fault, 1);
    bias = 32'd0;
    run_ones(2, w);
    chk("R4 word after bias removed", w, 4096);
    chk("R7 fault sticky", sat_fault, 1);
    @(negedge clk);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    chk("R7 fault cleared", sat_fault, 0);
    run_ones(2, w);
    chk("R7 fault stays clear", sat_fault, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule